// File: doc/BRIEF.md
# Segment Bitmap Frame Receiver

This block sits on the display side of a two-wire link. It takes in a stream of asynchronous serial bytes and rebuilds from it a flat bitmap in which each bit switches one display segment on or off. The bitmap is carried in a frame of 42 bytes. In every byte, the upper bit only marks alignment: it is set in the first byte of a frame and clear in all the others. The seven lower bits carry segment data.

The receiver oversamples the line, confirms each start bit at its midpoint and collects the seven payload bits of each byte in a shadow store. The visible bitmap changes in a single step, and only when the last byte of a correctly aligned frame arrives. At that moment a one-cycle strobe is raised. A bad alignment bit or a missing stop bit throws the partial frame away. The block then waits for the next byte with the marker bit set.

A supervision timer raises a link-loss flag when no complete frame has arrived within a set number of clock cycles. The flag drops again when the next good frame arrives. The block gives no meaning to any bitmap bit, and every combination of bits is passed on as received.

Top module: `seg_frame_rx`

## Requirements
- R1: The line format is one low start bit, 8 data bits sent least significant first, no parity and one high stop bit. A bit lasts 16 ticks, and a tick lasts OVS_DIV clock cycles. With the default parameters this gives 19.2 kbit/s at 200 MHz.
- R2: A low level on an idle line starts a byte only if the line is still low at the start bit's midpoint, 8 ticks later. A shorter low pulse is discarded and does not disturb the next frame.
- R3: A byte with bit 7 = 1 opens a frame and is stored as byte index 0. Bytes with bit 7 = 0 that arrive while no frame is open are ignored.
- R4: Bits [6:0] of frame byte n appear at seg_bitmap_o positions 7n (bit 0) through 7n+6 (bit 6), for n = 0 to 41.
- R5: seg_bitmap_o changes only when byte index 41 is received without error. A frame that stops short leaves the bitmap unchanged.
- R6: frame_valid_o is high for exactly one clock cycle per completed frame, in the same cycle in which the new bitmap first appears.
- R7: A byte with bit 7 = 1 that arrives while a frame is open drops that frame and starts a new one at index 0. The new frame completes 41 bytes later.
- R8: A stop bit sampled low aborts the open frame. Later bytes with bit 7 = 0 are ignored until the next byte with bit 7 = 1.
- R9: No bit combination is rejected. An all-ones payload and an all-zeros payload are both shown exactly as sent.
- R10: link_lost_o rises once TIMEOUT_CYCLES clock cycles have passed without a completed frame. It returns low in the cycle after the next frame_valid_o pulse.
- R11: After reset, seg_bitmap_o is all zeros and frame_valid_o and link_lost_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial_i | input | 1 | Serial receive line, idle high |
| seg_bitmap_o | output | 294 | Segment enables, byte n payload at bits 7n+6..7n |
| frame_valid_o | output | 1 | One-cycle strobe when a new bitmap is loaded |
| link_lost_o | output | 1 | High while no frame has completed within the timeout |

## Verification
Frames filled with random payloads, sent with random idle gaps between bytes, check the bit packing and the byte timing. Frames of all ones and all zeros would expose a payload lane that is stuck, shifted or leaking the alignment bit. Several directed sequences separate the four ways a frame can end: stray unaligned bytes before a sync byte, a frame cut short, a sync byte arriving in the middle of a frame, and a byte with a broken stop bit. A short low glitch on the line and a long silence exercise start-bit confirmation and the link-loss flag.

// File: rtl/seg_rx_pkg.sv
// Shared constants and types for the segment bitmap frame receiver.
// Assumes an 8N1 byte format with 16x oversampling.
package seg_rx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned PAYLOAD_W = 7;
    localparam int unsigned SYNC_POS  = 7;
    localparam int unsigned OVS       = 16;
    localparam int unsigned OVS_W     = $clog2(OVS);
    localparam int unsigned OVS_MID   = OVS / 2 - 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_t;
endpackage

// File: rtl/seg_uart_rx.sv
// Oversampling asynchronous byte receiver.
// Does: synchronises the line, confirms the start bit at its midpoint,
// samples 8 data bits LSB first at their midpoints, and checks the stop bit.
// Assumes: line idles high; OVS_DIV clock cycles per oversample tick.
// After a low stop bit it waits for the line to return high.
module seg_uart_rx
    import seg_rx_pkg::*;
#(
    parameter int unsigned OVS_DIV = 651
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_ok_o,
    output logic              frame_err_o
);
    logic [1:0]        sync_q;
    logic              rx_s;
    logic              tick;
    rx_state_t         state;
    logic [OVS_W-1:0]  os_cnt;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign rx_s   = sync_q[1];
    assign byte_o = shreg;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Oversample tick generator; a divider of one ticks every cycle.
    generate
        if (OVS_DIV <= 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int unsigned DIV_W = $clog2(OVS_DIV);
            logic [DIV_W-1:0] div_cnt;
            // Free-running divider.
            always_ff @(posedge clk) begin
                if (!rst_n)                               div_cnt <= '0;
                else if (div_cnt == DIV_W'(OVS_DIV - 1))  div_cnt <= '0;
                else                                      div_cnt <= div_cnt + 1'b1;
            end
            assign tick = (div_cnt == DIV_W'(OVS_DIV - 1));
        end
    endgenerate

    // Receive state machine: start confirm, data shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            os_cnt      <= '0;
            bit_cnt     <= '0;
            shreg       <= '0;
            byte_ok_o   <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            byte_ok_o   <= 1'b0;
            frame_err_o <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os_cnt == OVS_W'(OVS_MID)) begin
                            os_cnt  <= '0;
                            bit_cnt <= '0;
                            state   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (os_cnt == OVS_W'(OVS - 1)) begin
                            os_cnt <= '0;
                            shreg  <= {rx_s, shreg[BYTE_W-1:1]};
                            if (bit_cnt == 3'd7) state   <= RX_STOP;
                            else                 bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (os_cnt == OVS_W'(OVS - 1)) begin
                            os_cnt <= '0;
                            if (rx_s) begin
                                byte_ok_o <= 1'b1;
                                state     <= RX_IDLE;
                            end else begin
                                frame_err_o <= 1'b1;
                                state       <= RX_BREAK;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_BREAK: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // A byte needs many cycles, so a byte strobe is never repeated at once.
    assert_byte_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok_o |=> !byte_ok_o);

    // A framing error leaves the receiver waiting for the line to go high.
    assert_break_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (state == RX_BREAK || state == RX_IDLE));

    // A start is only accepted through the midpoint check.
    assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(rx_s));
endmodule

// File: rtl/seg_frame_asm.sv
// Frame aligner and payload packer.
// Does: opens a frame on a byte with the sync bit set, writes each payload
// into its slot of a shadow store, and loads the visible bitmap in one step
// when the last byte arrives. Assumes byte and error strobes are one cycle.
module seg_frame_asm
    import seg_rx_pkg::*;
#(
    parameter int unsigned NBYTES = 42
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BYTE_W-1:0]             byte_i,
    input  logic                          byte_ok_i,
    input  logic                          frame_err_i,
    output logic [NBYTES*PAYLOAD_W-1:0]   bitmap_o,
    output logic                          frame_valid_o
);
    localparam int unsigned IDX_W = $clog2(NBYTES);
    localparam int unsigned MAP_W = NBYTES * PAYLOAD_W;

    logic [MAP_W-1:0]  shadow;
    logic [IDX_W-1:0]  idx;
    logic              active;
    logic              is_sync;
    logic              last_byte;
    logic [NBYTES-1:0] slot_we;

    assign is_sync   = byte_i[SYNC_POS];
    assign last_byte = active && !is_sync && (idx == IDX_W'(NBYTES - 1));

    // Per-slot payload store: slot 0 on sync, slot idx inside a frame.
    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_slot
            if (g == 0) begin : g_first
                assign slot_we[g] = byte_ok_i && is_sync;
            end else begin : g_rest
                assign slot_we[g] = byte_ok_i && !is_sync && active
                                    && (idx == IDX_W'(g));
            end
            // Capture this slot's seven payload bits.
            always_ff @(posedge clk) begin
                if (!rst_n)          shadow[g*PAYLOAD_W +: PAYLOAD_W] <= '0;
                else if (slot_we[g]) shadow[g*PAYLOAD_W +: PAYLOAD_W] <= byte_i[PAYLOAD_W-1:0];
            end
        end
    endgenerate

    // Frame position tracking, abort handling and atomic bitmap load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active        <= 1'b0;
            idx           <= '0;
            bitmap_o      <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= 1'b0;
            if (frame_err_i) begin
                active <= 1'b0;
                idx    <= '0;
            end else if (byte_ok_i) begin
                if (is_sync) begin
                    active <= 1'b1;
                    idx    <= IDX_W'(1);
                end else if (last_byte) begin
                    bitmap_o      <= {byte_i[PAYLOAD_W-1:0],
                                      shadow[MAP_W-PAYLOAD_W-1:0]};
                    frame_valid_o <= 1'b1;
                    active        <= 1'b0;
                    idx           <= '0;
                end else if (active) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Index never leaves the frame.
    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(NBYTES));

    // Strobe lasts one cycle.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    // Visible bitmap only moves together with the strobe.
    assert_map_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> $stable(bitmap_o));

    // A framing error closes any open frame.
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_i |=> !active);

    // A sync byte always reopens at index 1 next.
    assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok_i && is_sync && !frame_err_i) |=> (active && idx == IDX_W'(1)));
endmodule

// File: rtl/seg_link_mon.sv
// Link supervision timer.
// Does: counts cycles since the last completed frame and raises a flag
// when the count reaches TIMEOUT_CYCLES. Assumes a one-cycle frame strobe.
module seg_link_mon #(
    parameter int unsigned TIMEOUT_CYCLES = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid_i,
    output logic link_lost_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Silence counter with flag set on expiry and clear on a good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            link_lost_o <= 1'b0;
        end else if (frame_valid_i) begin
            cnt         <= '0;
            link_lost_o <= 1'b0;
        end else if (cnt == CNT_W'(TIMEOUT_CYCLES - 1)) begin
            link_lost_o <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // A good frame clears the flag on the following cycle.
    assert_lost_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_i |=> !link_lost_o);

    // The flag never rises in the cycle right after a frame.
    assert_lost_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_lost_o) |-> !$past(frame_valid_i));
endmodule

// File: rtl/seg_frame_rx.sv
// Segment bitmap frame receiver top.
// Does: serial byte reception, frame alignment and packing, link timeout.
// Assumes: 42-byte frames with the sync flag in bit 7 of byte 0 only.
module seg_frame_rx
    import seg_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 200_000_000,
    parameter int unsigned BAUD_HZ        = 19_200,
    parameter int unsigned OVS_DIV        = CLK_HZ / (BAUD_HZ * OVS),
    parameter int unsigned NBYTES         = 42,
    parameter int unsigned TIMEOUT_CYCLES = CLK_HZ
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_serial_i,
    output logic [NBYTES*PAYLOAD_W-1:0] seg_bitmap_o,
    output logic                        frame_valid_o,
    output logic                        link_lost_o
);
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_ok;
    logic              rx_ferr;

    seg_uart_rx #(.OVS_DIV(OVS_DIV)) uart_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx_serial_i),
        .byte_o      (rx_byte),
        .byte_ok_o   (rx_ok),
        .frame_err_o (rx_ferr)
    );

    seg_frame_asm #(.NBYTES(NBYTES)) asm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_i        (rx_byte),
        .byte_ok_i     (rx_ok),
        .frame_err_i   (rx_ferr),
        .bitmap_o      (seg_bitmap_o),
        .frame_valid_o (frame_valid_o)
    );

    seg_link_mon #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) mon_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (frame_valid_o),
        .link_lost_o   (link_lost_o)
    );
endmodule

// File: tb/seg_frame_rx_tb_top.sv
`timescale 1ns/1ps
module seg_frame_rx_tb_top;
    localparam int NB    = 42;
    localparam int MW    = NB * 7;
    localparam int BIT   = 16;
    localparam int TMO   = 30000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic [MW-1:0] bitmap;
    logic          fvalid;
    logic          lost;

    always #2.5 clk = ~clk;

    seg_frame_rx #(
        .OVS_DIV(1), .NBYTES(NB), .TIMEOUT_CYCLES(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_serial_i(rx),
        .seg_bitmap_o(bitmap), .frame_valid_o(fvalid), .link_lost_o(lost)
    );

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;
    logic [7:0]    fr [NB];
    logic [MW-1:0] exp_map = '0;

    // Count strobe cycles away from the active edge.
    always @(negedge clk) if (rst_n && fvalid) pulses++;

    function automatic logic [MW-1:0] pack_frame();
        logic [MW-1:0] m = '0;
        for (int n = 0; n < NB; n++) m[n*7 +: 7] = fr[n][6:0];
        return m;
    endfunction

    task automatic chk_map(string tag);
        checks++;
        if (bitmap !== exp_map) begin
            fails++;
            $display("FAIL %s bitmap actual=%h expected=%h", tag, bitmap, exp_map);
        end
    endtask

    task automatic chk_int(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic idle_bits(int n);
        rx <= 1'b1;
        repeat (n * BIT) @(posedge clk);
    endtask

    task automatic send_byte(logic [7:0] b, bit good_stop);
        rx <= 1'b0;
        repeat (BIT) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            rx <= b[i];
            repeat (BIT) @(posedge clk);
        end
        rx <= good_stop;
        repeat (BIT) @(posedge clk);
        if (!good_stop) idle_bits(2);
    endtask

    task automatic rand_frame();
        for (int n = 0; n < NB; n++) begin
            logic [31:0] r = $urandom();
            fr[n] = {(n == 0), r[6:0]};
        end
    endtask

    task automatic send_frame();
        for (int n = 0; n < NB; n++) begin
            int g = $urandom_range(0, 2);
            send_byte(fr[n], 1'b1);
            if (g > 0) idle_bits(g);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic good_frame_check(string tag);
        int p0 = pulses;
        send_frame();
        exp_map = pack_frame();
        settle();
        chk_map(tag);
        chk_int({tag, " pulse"}, pulses - p0, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int p0;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_map("R11 reset");
        chk_int("R11 valid", int'(fvalid), 0);
        chk_int("R11 lost", int'(lost), 0);
        idle_bits(2);

        // R1 R4 R6 random payloads
        rand_frame(); good_frame_check("R4 random frame 1");
        rand_frame(); good_frame_check("R1 random frame 2");

        // R9 all ones, all zeros
        for (int n = 0; n < NB; n++) fr[n] = (n == 0) ? 8'hFF : 8'h7F;
        good_frame_check("R9 all ones");
        for (int n = 0; n < NB; n++) fr[n] = (n == 0) ? 8'h80 : 8'h00;
        good_frame_check("R9 all zeros");

        // R3 stray unaligned bytes before sync
        for (int k = 0; k < 5; k++) begin
            logic [31:0] r = $urandom();
            send_byte({1'b0, r[6:0]}, 1'b1);
        end
        rand_frame(); good_frame_check("R3 stray bytes");

        // R5 truncated frame leaves bitmap alone
        rand_frame();
        p0 = pulses;
        for (int n = 0; n < 20; n++) send_byte(fr[n], 1'b1);
        idle_bits(4); settle();
        chk_map("R5 truncated");
        chk_int("R5 no pulse", pulses - p0, 0);

        // R7 sync mid-frame restarts
        rand_frame();
        for (int n = 0; n < 14; n++) send_byte(fr[n], 1'b1);
        rand_frame(); good_frame_check("R7 restart");

        // R8 framing error aborts; trailing bytes ignored
        rand_frame();
        p0 = pulses;
        for (int n = 0; n < 11; n++) send_byte(fr[n], 1'b1);
        send_byte(8'h35, 1'b0);
        for (int n = 11; n < NB; n++) send_byte(fr[n], 1'b1);
        settle();
        chk_map("R8 abort");
        chk_int("R8 no pulse", pulses - p0, 0);
        rand_frame(); good_frame_check("R8 recovery");

        // R2 short low glitch
        rx <= 1'b0;
        repeat (4) @(posedge clk);
        idle_bits(2);
        rand_frame(); good_frame_check("R2 glitch");

        // R10 link loss
        chk_int("R10 lost low", int'(lost), 0);
        repeat (TMO - 400) @(posedge clk);
        @(negedge clk);
        chk_int("R10 before timeout", int'(lost), 0);
        repeat (600) @(posedge clk);
        @(negedge clk);
        chk_int("R10 after timeout", int'(lost), 1);
        rand_frame(); good_frame_check("R10 frame");
        chk_int("R10 cleared", int'(lost), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule